// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the control state machine for a multicycle 32-bit RISC datapath. That datapath has one cache that holds both instructions and data. Each instruction takes three to five clock cycles.

The controller reads three groups of inputs:
- the opcode and function fields of the instruction register;
- three ALU flags: zero, result bit 31 and signed overflow;
- an external illegal-instruction flag.

Each cycle it drives the enables and selects for the program counter, the cache port, the instruction register, the register file and the ALU. The datapath's holding registers (x, y, z and the memory data register) are outside the block. The controller only sequences them.

Every instruction runs the same first two cycles:
- **Fetch** reads the cache at the PC, loads the instruction register and writes PC+4 back into the PC.
- **Decode** reads the two source registers. It also computes the branch target PC + 4·imm into z before the instruction type is known, so a branch needs only one further cycle.

After decode the sequence splits by instruction class. Two exception states handle signed overflow and an unrecognised instruction. Each one saves the PC, redirects the PC to the system-call entry address and returns to fetch.

Top module: `mcyc_ctrl`

## Requirements
- R1: After reset the state output is 0 (fetch). In state 0 the outputs are:
  - mem_rd=1, ir_we=1, inst_data=0;
  - alu_src_x=0, alu_src_y=0;
  - an add operation (add_sub=0, fn_class=2);
  - pc_src=3 (ALU output) and pc_we=1.
- R2: State 0 is always followed by state 1 (decode). In state 1 the outputs are alu_src_x=0, alu_src_y=3 (4·imm) and an add, with no PC, cache or register write.
- R3: A register-format ALU instruction runs states 0, 1, 7, 8. The register-format instructions are opcode 0 with function 32 add, 34 sub, 42 slt, 36 and, 37 or, 38 xor or 39 nor.
  - State 7: alu_src_x=1, alu_src_y=1 (y register).
  - State 8: reg_we=1, reg_dst=1 (rd), reg_in_src=1 (z).
- R4: An immediate ALU instruction also runs states 0, 1, 7, 8, with alu_src_y=2 (imm) in state 7 and reg_dst=0 (rt) in state 8. The immediate instructions are opcode 15 lui, 8 addi, 10 slti, 12 andi, 13 ori and 14 xori.
- R5: In state 7 the ALU controls follow the operation. fn_class is 0 lui, 1 set-less, 2 arithmetic, 3 logic.
  - add, addi: add_sub=0, fn_class=2.
  - sub: add_sub=1, fn_class=2.
  - slt, slti: add_sub=1, fn_class=1.
  - logic operations: fn_class=3 with logic_fn = 0 and, 1 or, 2 xor, 3 nor (the immediate forms use the same codes).
  - lui: fn_class=0.
- R6: A load (opcode 35) runs states 0, 1, 2, 3, 4.
  - State 2: alu_src_x=1, alu_src_y=2, add.
  - State 3: inst_data=1, mem_rd=1.
  - State 4: reg_we=1, reg_dst=0, reg_in_src=0 (data register).
- R7: A store (opcode 43) runs states 0, 1, 2, 6. State 6 has inst_data=1 and mem_wr=1.
- R8: A branch runs states 0, 1, 5. The branches are opcode 4 equal, 5 not-equal and 1 less-than-zero.
  - State 5 subtracts with alu_src_x=1 and alu_src_y=1, and sets pc_src=2 (z).
  - pc_we is the zero flag for equal, its inverse for not-equal, and ALU bit 31 for less-than-zero.
- R9: A jump runs states 0, 1, 5 with pc_we=1 in state 5. The PC source in state 5 is:
  - opcode 2 or 3: pc_src=0, jump_sel=0 (jump target);
  - opcode 0 function 8: pc_src=1 (x register);
  - opcode 0 function 12: pc_src=0, jump_sel=1 (system-call address).
- R10: For opcode 3 (jump and link), state 5 also drives reg_we=1, reg_dst=2 (register 31) and reg_in_src=2 (PC).
- R11: Overflow trap:
  - In state 7, an active overflow flag during add, sub or addi moves the machine to state 9 instead of state 8. For every other operation the overflow flag has no effect.
  - State 9 drives epc_we=1, pc_we=1, pc_src=0 and jump_sel=1, and is followed by state 0.
- R12: In state 1, the illegal flag or an opcode/function pair not listed above moves the machine to state 10. State 10 drives the same outputs as state 9 and is followed by state 0.
- R13: Any output not set above for a state is 0, except fn_class, which defaults to 2. mem_rd and mem_wr are never both 1, and reg_we is 1 only in states 4, 8, or 5 with jump-and-link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 6 | Opcode field of the instruction register |
| funct_i | input | 6 | Function field of the instruction register |
| alu_zero_i | input | 1 | ALU result is zero |
| alu_msb_i | input | 1 | ALU result bit 31 |
| alu_ovf_i | input | 1 | ALU signed overflow |
| bad_op_i | input | 1 | External illegal-instruction flag |
| state_o | output | 4 | Current control state number |
| pc_we_o | output | 1 | PC write enable |
| pc_src_o | output | 2 | PC source: 0 jump address, 1 x, 2 z, 3 ALU |
| jump_sel_o | output | 1 | Jump address: 0 target field, 1 system-call address |
| epc_we_o | output | 1 | Save PC into the exception PC register |
| inst_data_o | output | 1 | Cache address: 0 PC, 1 z |
| mem_rd_o | output | 1 | Cache read |
| mem_wr_o | output | 1 | Cache write |
| ir_we_o | output | 1 | Instruction register load |
| reg_we_o | output | 1 | Register file write |
| reg_dst_o | output | 2 | Destination: 0 rt, 1 rd, 2 register 31 |
| reg_in_src_o | output | 2 | Write data: 0 data register, 1 z, 2 PC |
| alu_src_x_o | output | 1 | ALU x input: 0 PC, 1 x register |
| alu_src_y_o | output | 2 | ALU y input: 0 constant 4, 1 y, 2 imm, 3 4·imm |
| add_sub_o | output | 1 | 0 add, 1 subtract |
| logic_fn_o | output | 2 | 0 and, 1 or, 2 xor, 3 nor |
| fn_class_o | output | 2 | 0 lui, 1 set-less, 2 arithmetic, 3 logic |

## Verification
Every opcode and function pair runs through its full sequence, and the outputs are compared against the expected value in every cycle.
- **ALU operations:** running all thirteen confirms both the state-7 function encoding and the destination register of each format.
- **Branches:** each branch type is tried with the zero and sign flags set in several combinations, including one where only the flag of the wrong type is active. This shows that each branch samples its own flag.
- **Overflow:** overflow is raised during trapping operations and during non-trapping ones. The outcome must be state 9 for the first and state 8 for the second.
- **Illegal instructions:** these are exercised both through the external flag on a valid opcode and through unlisted codes.

// File: rtl/mcc_pkg.sv
`timescale 1ns/1ps
package mcc_pkg;
  localparam int OPW = 6;
  localparam int STW = 4;

  typedef enum logic [STW-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_LDRD   = 4'd3,
    ST_LDWB   = 4'd4,
    ST_XFER   = 4'd5,
    ST_STWR   = 4'd6,
    ST_EXEC   = 4'd7,
    ST_WBACK  = 4'd8,
    ST_OVF    = 4'd9,
    ST_ILL    = 4'd10
  } st_e;

  typedef enum logic [4:0] {
    OP_ADD, OP_SUB, OP_SLT, OP_AND, OP_OR, OP_XOR, OP_NOR,
    OP_LUI, OP_ADDI, OP_SLTI, OP_ANDI, OP_ORI, OP_XORI,
    OP_LW, OP_SW, OP_BLTZ, OP_BEQ, OP_BNE,
    OP_J, OP_JAL, OP_JR, OP_SYS, OP_BAD
  } op_e;

  typedef enum logic [2:0] {
    C_ALUR, C_ALUI, C_LOAD, C_STORE, C_BRANCH, C_JUMP, C_BAD
  } cls_e;

  localparam logic [1:0] FC_LUI = 2'd0, FC_SLT = 2'd1, FC_ARITH = 2'd2, FC_LOGIC = 2'd3;
  localparam logic [1:0] PCS_JUMP = 2'd0, PCS_XREG = 2'd1, PCS_ZREG = 2'd2, PCS_ALU = 2'd3;
  localparam logic [1:0] SY_FOUR = 2'd0, SY_YREG = 2'd1, SY_IMM = 2'd2, SY_IMM4 = 2'd3;
  localparam logic [1:0] RD_RT = 2'd0, RD_RD = 2'd1, RD_R31 = 2'd2;
  localparam logic [1:0] RIS_DATA = 2'd0, RIS_Z = 2'd1, RIS_PC = 2'd2;

  typedef struct packed {
    logic       add_sub;
    logic [1:0] logic_fn;
    logic [1:0] fn_class;
  } alu_t;

  typedef struct packed {
    logic       pc_we;
    logic [1:0] pc_src;
    logic       jump_sel;
    logic       epc_we;
    logic       inst_data;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_we;
    logic       reg_we;
    logic [1:0] reg_dst;
    logic [1:0] reg_in_src;
    logic       alu_src_x;
    logic [1:0] alu_src_y;
    alu_t       alu;
  } ctl_t;

  function automatic op_e decode_op(input logic [OPW-1:0] opc, input logic [OPW-1:0] fn);
    op_e r;
    case (opc)
      6'd0: begin
        case (fn)
          6'd32:   r = OP_ADD;
          6'd34:   r = OP_SUB;
          6'd42:   r = OP_SLT;
          6'd36:   r = OP_AND;
          6'd37:   r = OP_OR;
          6'd38:   r = OP_XOR;
          6'd39:   r = OP_NOR;
          6'd8:    r = OP_JR;
          6'd12:   r = OP_SYS;
          default: r = OP_BAD;
        endcase
      end
      6'd1:    r = OP_BLTZ;
      6'd2:    r = OP_J;
      6'd3:    r = OP_JAL;
      6'd4:    r = OP_BEQ;
      6'd5:    r = OP_BNE;
      6'd8:    r = OP_ADDI;
      6'd10:   r = OP_SLTI;
      6'd12:   r = OP_ANDI;
      6'd13:   r = OP_ORI;
      6'd14:   r = OP_XORI;
      6'd15:   r = OP_LUI;
      6'd35:   r = OP_LW;
      6'd43:   r = OP_SW;
      default: r = OP_BAD;
    endcase
    return r;
  endfunction

  function automatic cls_e class_of(input op_e op);
    case (op)
      OP_ADD, OP_SUB, OP_SLT, OP_AND, OP_OR, OP_XOR, OP_NOR: return C_ALUR;
      OP_LUI, OP_ADDI, OP_SLTI, OP_ANDI, OP_ORI, OP_XORI:    return C_ALUI;
      OP_LW:                                                 return C_LOAD;
      OP_SW:                                                 return C_STORE;
      OP_BLTZ, OP_BEQ, OP_BNE:                               return C_BRANCH;
      OP_J, OP_JAL, OP_JR, OP_SYS:                           return C_JUMP;
      default:                                               return C_BAD;
    endcase
  endfunction

  function automatic alu_t alu_of(input op_e op);
    alu_t a;
    a = '{add_sub: 1'b0, logic_fn: 2'd0, fn_class: FC_ARITH};
    case (op)
      OP_SUB:          a.add_sub = 1'b1;
      OP_SLT, OP_SLTI: begin a.add_sub = 1'b1; a.fn_class = FC_SLT; end
      OP_AND, OP_ANDI: begin a.fn_class = FC_LOGIC; a.logic_fn = 2'd0; end
      OP_OR,  OP_ORI:  begin a.fn_class = FC_LOGIC; a.logic_fn = 2'd1; end
      OP_XOR, OP_XORI: begin a.fn_class = FC_LOGIC; a.logic_fn = 2'd2; end
      OP_NOR:          begin a.fn_class = FC_LOGIC; a.logic_fn = 2'd3; end
      OP_LUI:          a.fn_class = FC_LUI;
      default:         a.fn_class = FC_ARITH;
    endcase
    return a;
  endfunction

  function automatic logic traps_on_ovf(input op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADDI);
  endfunction

  function automatic logic branch_cond(input op_e op, input logic zero, input logic msb);
    case (op)
      OP_BEQ:  return zero;
      OP_BNE:  return !zero;
      OP_BLTZ: return msb;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mcc_decode.sv
`timescale 1ns/1ps
module mcc_decode
  import mcc_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  input  logic [OPW-1:0] funct,
  input  logic           bad_op,
  output op_e            op,
  output cls_e           cls,
  output logic           illegal
);
  always_comb begin
    op      = decode_op(opcode, funct);
    cls     = class_of(op);
    illegal = bad_op || (cls == C_BAD);
  end
endmodule

// File: rtl/mcc_next.sv
`timescale 1ns/1ps
module mcc_next
  import mcc_pkg::*;
(
  input  st_e  state,
  input  cls_e cls,
  input  logic ovf_trap,
  input  logic ill_trap,
  output st_e  state_nx
);
  always_comb begin
    case (state)
      ST_FETCH:  state_nx = ST_DECODE;
      ST_DECODE: begin
        if (ill_trap) state_nx = ST_ILL;
        else begin
          case (cls)
            C_ALUR, C_ALUI:    state_nx = ST_EXEC;
            C_LOAD, C_STORE:   state_nx = ST_ADDR;
            C_BRANCH, C_JUMP:  state_nx = ST_XFER;
            default:           state_nx = ST_ILL;
          endcase
        end
      end
      ST_ADDR:  state_nx = (cls == C_LOAD) ? ST_LDRD : ST_STWR;
      ST_LDRD:  state_nx = ST_LDWB;
      ST_EXEC:  state_nx = ovf_trap ? ST_OVF : ST_WBACK;
      default:  state_nx = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcc_outs.sv
`timescale 1ns/1ps
module mcc_outs
  import mcc_pkg::*;
(
  input  st_e  state,
  input  op_e  op,
  input  cls_e cls,
  input  logic br_taken,
  output ctl_t ctl
);
  always_comb begin
    ctl = '0;
    ctl.alu.fn_class = FC_ARITH;
    case (state)
      ST_FETCH: begin
        ctl.mem_rd = 1'b1;
        ctl.ir_we  = 1'b1;
        ctl.pc_src = PCS_ALU;
        ctl.pc_we  = 1'b1;
      end
      ST_DECODE: ctl.alu_src_y = SY_IMM4;
      ST_ADDR: begin
        ctl.alu_src_x = 1'b1;
        ctl.alu_src_y = SY_IMM;
      end
      ST_LDRD: begin
        ctl.inst_data = 1'b1;
        ctl.mem_rd    = 1'b1;
      end
      ST_LDWB: begin
        ctl.reg_we     = 1'b1;
        ctl.reg_dst    = RD_RT;
        ctl.reg_in_src = RIS_DATA;
      end
      ST_XFER: begin
        ctl.alu_src_x   = 1'b1;
        ctl.alu_src_y   = SY_YREG;
        ctl.alu.add_sub = 1'b1;
        case (op)
          OP_BLTZ, OP_BEQ, OP_BNE: begin
            ctl.pc_src = PCS_ZREG;
            ctl.pc_we  = br_taken;
          end
          OP_J: ctl.pc_we = 1'b1;
          OP_JAL: begin
            ctl.pc_we      = 1'b1;
            ctl.reg_we     = 1'b1;
            ctl.reg_dst    = RD_R31;
            ctl.reg_in_src = RIS_PC;
          end
          OP_JR: begin
            ctl.pc_src = PCS_XREG;
            ctl.pc_we  = 1'b1;
          end
          OP_SYS: begin
            ctl.jump_sel = 1'b1;
            ctl.pc_we    = 1'b1;
          end
          default: ctl.pc_we = 1'b0;
        endcase
      end
      ST_STWR: begin
        ctl.inst_data = 1'b1;
        ctl.mem_wr    = 1'b1;
      end
      ST_EXEC: begin
        ctl.alu_src_x = 1'b1;
        ctl.alu_src_y = (cls == C_ALUI) ? SY_IMM : SY_YREG;
        ctl.alu       = alu_of(op);
      end
      ST_WBACK: begin
        ctl.reg_we     = 1'b1;
        ctl.reg_dst    = (cls == C_ALUR) ? RD_RD : RD_RT;
        ctl.reg_in_src = RIS_Z;
      end
      ST_OVF, ST_ILL: begin
        ctl.epc_we   = 1'b1;
        ctl.jump_sel = 1'b1;
        ctl.pc_src   = PCS_JUMP;
        ctl.pc_we    = 1'b1;
      end
      default: ctl.pc_we = 1'b0;
    endcase
  end
endmodule

// File: rtl/mcyc_ctrl.sv
`timescale 1ns/1ps
module mcyc_ctrl
  import mcc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] opcode_i,
  input  logic [OPW-1:0] funct_i,
  input  logic           alu_zero_i,
  input  logic           alu_msb_i,
  input  logic           alu_ovf_i,
  input  logic           bad_op_i,
  output logic [STW-1:0] state_o,
  output logic           pc_we_o,
  output logic [1:0]     pc_src_o,
  output logic           jump_sel_o,
  output logic           epc_we_o,
  output logic           inst_data_o,
  output logic           mem_rd_o,
  output logic           mem_wr_o,
  output logic           ir_we_o,
  output logic           reg_we_o,
  output logic [1:0]     reg_dst_o,
  output logic [1:0]     reg_in_src_o,
  output logic           alu_src_x_o,
  output logic [1:0]     alu_src_y_o,
  output logic           add_sub_o,
  output logic [1:0]     logic_fn_o,
  output logic [1:0]     fn_class_o
);
  st_e  state_q, state_d;
  op_e  op;
  cls_e cls;
  logic illegal;
  ctl_t ctl;

  // named events for the checker
  logic ovf_trap, ill_trap, br_taken;

  mcc_decode u_dec (
    .opcode (opcode_i),
    .funct  (funct_i),
    .bad_op (bad_op_i),
    .op     (op),
    .cls    (cls),
    .illegal(illegal)
  );

  assign ovf_trap = (state_q == ST_EXEC) && alu_ovf_i && traps_on_ovf(op);
  assign ill_trap = (state_q == ST_DECODE) && illegal;
  assign br_taken = branch_cond(op, alu_zero_i, alu_msb_i);

  mcc_next u_nxt (
    .state   (state_q),
    .cls     (cls),
    .ovf_trap(ovf_trap),
    .ill_trap(ill_trap),
    .state_nx(state_d)
  );

  mcc_outs u_out (
    .state   (state_q),
    .op      (op),
    .cls     (cls),
    .br_taken(br_taken),
    .ctl     (ctl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  assign state_o      = state_q;
  assign pc_we_o      = ctl.pc_we;
  assign pc_src_o     = ctl.pc_src;
  assign jump_sel_o   = ctl.jump_sel;
  assign epc_we_o     = ctl.epc_we;
  assign inst_data_o  = ctl.inst_data;
  assign mem_rd_o     = ctl.mem_rd;
  assign mem_wr_o     = ctl.mem_wr;
  assign ir_we_o      = ctl.ir_we;
  assign reg_we_o     = ctl.reg_we;
  assign reg_dst_o    = ctl.reg_dst;
  assign reg_in_src_o = ctl.reg_in_src;
  assign alu_src_x_o  = ctl.alu_src_x;
  assign alu_src_y_o  = ctl.alu_src_y;
  assign add_sub_o    = ctl.alu.add_sub;
  assign logic_fn_o   = ctl.alu.logic_fn;
  assign fn_class_o   = ctl.alu.fn_class;
endmodule

// File: rtl/mcc_check.sv
`timescale 1ns/1ps
module mcc_check (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] state,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       reg_we,
  input logic       pc_we,
  input logic       ovf_trap,
  input logic       ill_trap
);
  p_fetch_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd0 |=> state == 4'd1);

  p_load_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd3 |=> state == 4'd4);

  p_xfer_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd5 |=> state == 4'd0);

  p_ovf_trap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |=> state == 4'd9);

  p_exc_return_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd9 || state == 4'd10) |=> state == 4'd0);

  p_ill_trap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ill_trap |=> state == 4'd10);

  p_mem_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_regwe_states_r13: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (state == 4'd4 || state == 4'd8 || state == 4'd5));

  p_pcwe_states_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> (state == 4'd0 || state == 4'd5 || state == 4'd9 || state == 4'd10));
endmodule

bind mcyc_ctrl mcc_check u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .state   (state_o),
  .mem_rd  (mem_rd_o),
  .mem_wr  (mem_wr_o),
  .reg_we  (reg_we_o),
  .pc_we   (pc_we_o),
  .ovf_trap(ovf_trap),
  .ill_trap(ill_trap)
);

// File: tb/sim_mcyc_ctrl.sv
`timescale 1ns/1ps
module sim_mcyc_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] opc = '0, fnc = '0;
  logic       zf = 1'b0, mf = 1'b0, of = 1'b0, bo = 1'b0;

  logic [3:0] state_o;
  logic pc_we_o, jump_sel_o, epc_we_o, inst_data_o, mem_rd_o, mem_wr_o, ir_we_o, reg_we_o;
  logic alu_src_x_o, add_sub_o;
  logic [1:0] pc_src_o, reg_dst_o, reg_in_src_o, alu_src_y_o, logic_fn_o, fn_class_o;

  int n_run = 0, n_fail = 0;

  mcyc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .opcode_i(opc), .funct_i(fnc),
    .alu_zero_i(zf), .alu_msb_i(mf), .alu_ovf_i(of), .bad_op_i(bo),
    .state_o(state_o), .pc_we_o(pc_we_o), .pc_src_o(pc_src_o), .jump_sel_o(jump_sel_o),
    .epc_we_o(epc_we_o), .inst_data_o(inst_data_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .ir_we_o(ir_we_o), .reg_we_o(reg_we_o), .reg_dst_o(reg_dst_o), .reg_in_src_o(reg_in_src_o),
    .alu_src_x_o(alu_src_x_o), .alu_src_y_o(alu_src_y_o), .add_sub_o(add_sub_o),
    .logic_fn_o(logic_fn_o), .fn_class_o(fn_class_o)
  );

  always #4 clk = ~clk;

  function automatic logic [25:0] pk(input int st, input int pw, input int ps, input int js,
      input int ep, input int id, input int mr, input int mw, input int ir, input int rw,
      input int rd, input int ris, input int sx, input int sy, input int asb, input int lf,
      input int fc);
    return {st[3:0], pw[0], ps[1:0], js[0], ep[0], id[0], mr[0], mw[0], ir[0], rw[0],
            rd[1:0], ris[1:0], sx[0], sy[1:0], asb[0], lf[1:0], fc[1:0]};
  endfunction

  function automatic logic [25:0] act();
    return {state_o, pc_we_o, pc_src_o, jump_sel_o, epc_we_o, inst_data_o, mem_rd_o, mem_wr_o,
            ir_we_o, reg_we_o, reg_dst_o, reg_in_src_o, alu_src_x_o, alu_src_y_o, add_sub_o,
            logic_fn_o, fn_class_o};
  endfunction

  task automatic chk(input string tg, input logic [25:0] exp);
    n_run++;
    if (act() !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tg, act(), exp);
    end
  endtask

  function automatic logic [25:0] e_fetch();
    return pk(0, 1, 3, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 2);
  endfunction
  function automatic logic [25:0] e_dec();
    return pk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3, 0, 0, 2);
  endfunction
  function automatic logic [25:0] e_exc(input int st);
    return pk(st, 1, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2);
  endfunction

  task automatic nx();
    @(negedge clk);
  endtask

  task automatic start(input string tg, input int op, input int fn, input bit z, input bit m,
                       input bit o, input bit b);
    opc = op[5:0]; fnc = fn[5:0]; zf = z; mf = m; of = o; bo = b;
    #1;
    chk({"R1 fetch ", tg}, e_fetch());
    nx();
    chk({"R2 decode ", tg}, e_dec());
  endtask

  // R3 R4 R5 R11: ALU operations, with or without overflow
  task automatic run_alu(input string tg, input int op, input int fn, input bit imm,
                         input int asb, input int lf, input int fc, input bit o, input bit trap);
    start(tg, op, fn, 0, 0, o, 0);
    nx();
    chk({"R5 exec ", tg}, pk(7, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, imm ? 2 : 1, asb, lf, fc));
    nx();
    if (trap) chk({"R11 ovf trap ", tg}, e_exc(9));
    else chk({imm ? "R4 wb " : "R3 wb ", tg},
             pk(8, 0, 0, 0, 0, 0, 0, 0, 0, 1, imm ? 0 : 1, 1, 0, 0, 0, 0, 2));
    nx();
  endtask

  task automatic run_load();
    start("R6 lw", 35, 0, 0, 0, 0, 0);
    nx(); chk("R6 addr", pk(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 0, 0, 2));
    nx(); chk("R6 read", pk(3, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2));
    nx(); chk("R6 wb",   pk(4, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 2));
    nx();
  endtask

  task automatic run_store();
    start("R7 sw", 43, 0, 0, 0, 0, 0);
    nx(); chk("R7 addr",  pk(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 0, 0, 2));
    nx(); chk("R7 write", pk(6, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 2));
    nx();
  endtask

  task automatic run_br(input string tg, input int op, input bit z, input bit m, input int we);
    start(tg, op, 0, z, m, 0, 0);
    nx();
    chk({"R8 ", tg}, pk(5, we, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 2));
    nx();
  endtask

  task automatic run_jmp(input string tg, input int op, input int fn, input int ps,
                         input int js, input bit lnk);
    start(tg, op, fn, 0, 0, 0, 0);
    nx();
    chk({lnk ? "R10 " : "R9 ", tg},
        pk(5, 1, ps, js, 0, 0, 0, 0, 0, lnk, lnk ? 2 : 0, lnk ? 2 : 0, 1, 1, 1, 0, 2));
    nx();
  endtask

  task automatic run_ill(input string tg, input int op, input int fn, input bit b);
    start(tg, op, fn, 0, 0, 0, b);
    nx();
    chk({"R12 ", tg}, e_exc(10));
    nx();
  endtask

  initial begin
    #1600000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    #1;
    chk("R1 reset", e_fetch());
    repeat (3) @(negedge clk);
    chk("R1 reset held", e_fetch());
    rst_n = 1'b1;

    run_alu("add",  0, 32, 0, 0, 0, 2, 0, 0);
    run_alu("sub",  0, 34, 0, 1, 0, 2, 0, 0);
    run_alu("slt",  0, 42, 0, 1, 0, 1, 0, 0);
    run_alu("and",  0, 36, 0, 0, 0, 3, 0, 0);
    run_alu("or",   0, 37, 0, 0, 1, 3, 0, 0);
    run_alu("xor",  0, 38, 0, 0, 2, 3, 0, 0);
    run_alu("nor",  0, 39, 0, 0, 3, 3, 0, 0);
    run_alu("lui",  15, 0, 1, 0, 0, 0, 0, 0);
    run_alu("addi", 8,  0, 1, 0, 0, 2, 0, 0);
    run_alu("slti", 10, 0, 1, 1, 0, 1, 0, 0);
    run_alu("andi", 12, 0, 1, 0, 0, 3, 0, 0);
    run_alu("ori",  13, 0, 1, 0, 1, 3, 0, 0);
    run_alu("xori", 14, 0, 1, 0, 2, 3, 0, 0);

    run_alu("R11 add ovf",  0, 32, 0, 0, 0, 2, 1, 1);
    run_alu("R11 sub ovf",  0, 34, 0, 1, 0, 2, 1, 1);
    run_alu("R11 addi ovf", 8, 0,  1, 0, 0, 2, 1, 1);
    run_alu("R11 slt ovf ignored",  0, 42, 0, 1, 0, 1, 1, 0);
    run_alu("R11 andi ovf ignored", 12, 0, 1, 0, 0, 3, 1, 0);

    run_load();
    run_store();

    run_br("beq taken",        4, 1, 0, 1);
    run_br("beq not taken",    4, 0, 0, 0);
    run_br("beq msb only",     4, 0, 1, 0);
    run_br("bne taken",        5, 0, 0, 1);
    run_br("bne not taken",    5, 1, 0, 0);
    run_br("bltz taken",       1, 0, 1, 1);
    run_br("bltz zero only",   1, 1, 0, 0);

    run_jmp("j",       2, 0,  0, 0, 0);
    run_jmp("jal",     3, 0,  0, 0, 1);
    run_jmp("jr",      0, 8,  1, 0, 0);
    run_jmp("syscall", 0, 12, 0, 1, 0);

    run_ill("flag on add", 0, 32, 1);
    run_ill("opcode 63",   63, 0, 0);
    run_ill("funct 0",     0, 0, 0);
    run_ill("opcode 9",    9, 0, 0);

    run_alu("R3 add after traps", 0, 32, 0, 0, 0, 2, 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule